// File: doc/BRIEF.md
# Character-Row Vertical Timing Generator

This block produces the vertical half of the timing for a display controller built around character rows. Each time the horizontal timing reports the end of a scanline, the block steps a scanline-within-row counter. When that counter wraps, it steps a character-row counter. After the last row of a cycle it can add a programmable tail of extra scanlines before the next cycle begins. From this state it derives a vertical display-enable, a cursor-enable gate, a VSync pulse and the memory address of the current character row.

The geometry inputs and the start address are taken only at the moment a cycle begins. Software can therefore rewrite them while a cycle is running and have the new values shape the next cycle. A single video frame can be built from two or more back-to-back cycles with different row counts and tails. Moving scanlines between the tails of two such cycles shifts the content of the second cycle by single scanlines while the frame length stays constant. The skew controls are applied live, so a mid-cycle write can blank the display-enable or cursor-enable and later restore it.

Top module: `vt_crtc_vert`

## Requirements
- R1: A cycle holds (r_vtotal+1) character rows of (r_maxras+1) scanlines each, followed by r_adjust tail scanlines. `raster` shows the scanline within the current row (0..r_maxras) and changes only on the clock edge at which `hend` is sampled high.
- R2: r_adjust accepts 0 to 31. The tail scanlines follow the final row. During the tail, `raster` counts 0..r_adjust-1, and the row index is r_vtotal+1.
- R3: At the start of a cycle, `row_addr` loads r_start. At the end of every character row, including the last one before the tail, it adds r_hdisp, modulo 2^14. It stays constant through the tail.
- R4: r_vtotal, r_maxras, r_adjust, r_vdisp, r_vspos, r_vslen, r_start and r_hdisp are sampled only at cycle start. A change made during a cycle affects only the following cycle.
- R5: VSync goes high one clock after the first scanline of the row whose index equals r_vspos begins. If the row counter never reaches that value (for example 255), the cycle has no VSync.
- R6: The VSync pulse lasts r_vslen scanlines. The value 0 means 16.
- R7: The vertical visibility is true while the row index is below r_vdisp. Tail lines count as row r_vtotal+1, so they are shown when r_vdisp > r_vtotal. `disp_en` follows visibility 1+d clocks late, where d = r_skew[1:0] is 0, 1 or 2. Code 3 forces `disp_en` low. The skew code is applied live and is not latched.
- R8: `curs_en` follows the same visibility with delay code r_skew[3:2], using the same encoding as R7, including code 3 = forced low.
- R9: `cycle_end` is a one-clock pulse, issued together with the first scanline of each new cycle, on the edge at which `hend` ended the previous cycle.
- R10: While `rst` is high, the block sits at row 0, scanline 0. In that state `row_addr` = r_start, `vsync` = 0, `disp_en` = 0, `curs_en` = 0 and `cycle_end` = 0, and the geometry is latched from the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous active-high reset |
| hend | input | 1 | One-clock strobe at the end of each scanline |
| r_vtotal | input | 8 | Last character row index of a cycle |
| r_maxras | input | 5 | Last scanline index within a row |
| r_adjust | input | 5 | Tail scanlines after the last row |
| r_vdisp | input | 8 | Number of displayed rows |
| r_vspos | input | 8 | Row index at which VSync begins |
| r_vslen | input | 4 | VSync width in scanlines (0 = 16) |
| r_skew | input | 4 | [1:0] display delay code, [3:2] cursor delay code |
| r_start | input | 14 | Start address for the first row |
| r_hdisp | input | 8 | Address step per character row |
| disp_en | output | 1 | Skewed vertical display-enable |
| curs_en | output | 1 | Skewed cursor-enable gate |
| vsync | output | 1 | Vertical sync pulse |
| row_addr | output | 14 | Address of the current character row |
| raster | output | 5 | Scanline within row, or within the tail |
| cycle_end | output | 1 | Pulse at the first scanline of each cycle |

## Verification
Three events can fall on the same `hend` edge. The closing of the last row can coincide with the start of a new cycle, so the new cycle's latched geometry and VSync row decide the very first scanline. A live skew change can also land on the scanline where visibility flips. The bench runs a chain of cycles and writes the following cycle's geometry one line into each running cycle. One cycle has a zero tail, and one has VSync on row 0 with a one-scanline pulse, so that the boundary and the pulse start coincide. The skew code changes exactly at cycle boundaries where visibility also changes. Every output is compared on every scanline against values computed from the cycle formula, with the display gates checked clock by clock after each edge.

// File: rtl/vt_pkg.sv
package vt_pkg;

  typedef enum logic [1:0] {
    SKEW_NONE  = 2'd0,
    SKEW_ONE   = 2'd1,
    SKEW_TWO   = 2'd2,
    SKEW_BLANK = 2'd3
  } skew_e;

  localparam int SKEW_MAX     = 2;
  localparam int SYNC_FIELD_W = 4;
  localparam int SYNC_CNT_W   = SYNC_FIELD_W + 1;

  function automatic logic [SYNC_CNT_W-1:0] pulse_len(input logic [SYNC_FIELD_W-1:0] f);
    if (f == '0) return SYNC_CNT_W'(1 << SYNC_FIELD_W);
    return {1'b0, f};
  endfunction

endpackage

// File: rtl/vt_scan_ctr.sv
module vt_scan_ctr #(
  parameter int ROW_W  = 8,
  parameter int RAS_W  = 5,
  parameter int ADJ_W  = 5,
  parameter int ADDR_W = 14,
  parameter int HD_W   = 8,
  parameter int SYN_W  = 4,
  localparam int CNT_W = (RAS_W > ADJ_W) ? RAS_W : ADJ_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hend,
  input  logic [ROW_W-1:0]  r_vtotal,
  input  logic [RAS_W-1:0]  r_maxras,
  input  logic [ADJ_W-1:0]  r_adjust,
  input  logic [ROW_W-1:0]  r_vdisp,
  input  logic [ROW_W-1:0]  r_vspos,
  input  logic [SYN_W-1:0]  r_vslen,
  input  logic [ADDR_W-1:0] r_start,
  input  logic [HD_W-1:0]   r_hdisp,
  output logic [ROW_W:0]    row,
  output logic [CNT_W-1:0]  raster,
  output logic [ADDR_W-1:0] row_addr,
  output logic              cycle_end,
  output logic              line_start,
  output logic [ROW_W-1:0]  lat_vdisp,
  output logic [ROW_W-1:0]  lat_vspos,
  output logic [SYN_W-1:0]  lat_vslen
);

  logic [ROW_W-1:0] lat_vtotal;
  logic [RAS_W-1:0] lat_maxras;
  logic [ADJ_W-1:0] lat_adjust;
  logic [HD_W-1:0]  lat_hdisp;
  logic             in_tail;

  logic row_last, ras_last, tail_done, begin_cycle;

  always_comb begin
    row_last    = (row == {1'b0, lat_vtotal});
    ras_last    = (raster == CNT_W'(lat_maxras));
    tail_done   = in_tail && (({1'b0, raster} + 1'b1) == (CNT_W+1)'(lat_adjust));
    begin_cycle = hend && (tail_done ||
                  (!in_tail && ras_last && row_last && (lat_adjust == '0)));
  end

  // geometry snapshot, taken only where a cycle begins
  always_ff @(posedge clk) begin
    if (rst || begin_cycle) begin
      lat_vtotal <= r_vtotal;
      lat_maxras <= r_maxras;
      lat_adjust <= r_adjust;
      lat_vdisp  <= r_vdisp;
      lat_vspos  <= r_vspos;
      lat_vslen  <= r_vslen;
      lat_hdisp  <= r_hdisp;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      row        <= '0;
      raster     <= '0;
      in_tail    <= 1'b0;
      row_addr   <= r_start;
      cycle_end  <= 1'b0;
      line_start <= 1'b0;
    end else begin
      cycle_end  <= 1'b0;
      line_start <= hend;
      if (begin_cycle) begin
        row       <= '0;
        raster    <= '0;
        in_tail   <= 1'b0;
        row_addr  <= r_start;
        cycle_end <= 1'b1;
      end else if (hend) begin
        if (in_tail) begin
          raster <= raster + 1'b1;
        end else if (ras_last) begin
          raster   <= '0;
          row      <= row + 1'b1;
          row_addr <= row_addr + ADDR_W'(lat_hdisp);
          if (row_last) in_tail <= 1'b1;
        end else begin
          raster <= raster + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/vt_vsync.sv
module vt_vsync
  import vt_pkg::*;
#(
  parameter int ROW_W = 8,
  parameter int CNT_W = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    line_start,
  input  logic [ROW_W:0]          row,
  input  logic [CNT_W-1:0]        raster,
  input  logic [ROW_W-1:0]        lat_vspos,
  input  logic [SYNC_FIELD_W-1:0] lat_vslen,
  output logic                    vsync
);

  logic [SYNC_CNT_W-1:0] left_q, left_d;
  logic                  hit;

  always_comb begin
    hit = line_start && (row == {1'b0, lat_vspos}) && (raster == '0);
    if (hit)                            left_d = pulse_len(lat_vslen);
    else if (line_start && left_q != '0) left_d = left_q - 1'b1;
    else                                left_d = left_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
      vsync  <= 1'b0;
    end else begin
      left_q <= left_d;
      vsync  <= (left_d != '0);
    end
  end

endmodule

// File: rtl/vt_skew.sv
module vt_skew
  import vt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       vis,
  input  logic [1:0] code,
  output logic       en
);

  logic [SKEW_MAX:1] hist;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0;
      en   <= 1'b0;
    end else begin
      hist <= {hist[SKEW_MAX-1:1], vis};
      case (skew_e'(code))
        SKEW_NONE: en <= vis;
        SKEW_ONE:  en <= hist[1];
        SKEW_TWO:  en <= hist[2];
        default:   en <= 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/vt_crtc_vert.sv
module vt_crtc_vert #(
  parameter int ROW_W  = 8,
  parameter int RAS_W  = 5,
  parameter int ADJ_W  = 5,
  parameter int ADDR_W = 14,
  parameter int HD_W   = 8,
  localparam int CNT_W = (RAS_W > ADJ_W) ? RAS_W : ADJ_W,
  localparam int SYN_W = vt_pkg::SYNC_FIELD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hend,
  input  logic [ROW_W-1:0]  r_vtotal,
  input  logic [RAS_W-1:0]  r_maxras,
  input  logic [ADJ_W-1:0]  r_adjust,
  input  logic [ROW_W-1:0]  r_vdisp,
  input  logic [ROW_W-1:0]  r_vspos,
  input  logic [SYN_W-1:0]  r_vslen,
  input  logic [3:0]        r_skew,
  input  logic [ADDR_W-1:0] r_start,
  input  logic [HD_W-1:0]   r_hdisp,
  output logic              disp_en,
  output logic              curs_en,
  output logic              vsync,
  output logic [ADDR_W-1:0] row_addr,
  output logic [CNT_W-1:0]  raster,
  output logic              cycle_end
);

  logic [ROW_W:0]   row;
  logic             line_start;
  logic [ROW_W-1:0] lat_vdisp, lat_vspos;
  logic [SYN_W-1:0] lat_vslen;
  logic             vis;
  logic [1:0]       gate_en;

  vt_scan_ctr #(
    .ROW_W(ROW_W), .RAS_W(RAS_W), .ADJ_W(ADJ_W),
    .ADDR_W(ADDR_W), .HD_W(HD_W), .SYN_W(SYN_W)
  ) u_ctr (
    .clk(clk), .rst(rst), .hend(hend),
    .r_vtotal(r_vtotal), .r_maxras(r_maxras), .r_adjust(r_adjust),
    .r_vdisp(r_vdisp), .r_vspos(r_vspos), .r_vslen(r_vslen),
    .r_start(r_start), .r_hdisp(r_hdisp),
    .row(row), .raster(raster), .row_addr(row_addr),
    .cycle_end(cycle_end), .line_start(line_start),
    .lat_vdisp(lat_vdisp), .lat_vspos(lat_vspos), .lat_vslen(lat_vslen)
  );

  vt_vsync #(.ROW_W(ROW_W), .CNT_W(CNT_W)) u_vs (
    .clk(clk), .rst(rst), .line_start(line_start),
    .row(row), .raster(raster),
    .lat_vspos(lat_vspos), .lat_vslen(lat_vslen),
    .vsync(vsync)
  );

  assign vis = (row < {1'b0, lat_vdisp});

  // gate 0: display-enable, gate 1: cursor-enable
  for (genvar k = 0; k < 2; k++) begin : g_gate
    vt_skew u_skew (
      .clk(clk), .rst(rst), .vis(vis),
      .code(r_skew[2*k +: 2]),
      .en(gate_en[k])
    );
  end

  assign disp_en = gate_en[0];
  assign curs_en = gate_en[1];

endmodule

// File: rtl/vt_chk.sv
module vt_chk #(
  parameter int ADDR_W = 14,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              hend,
  input logic [3:0]        r_skew,
  input logic [ADDR_W-1:0] r_start,
  input logic [ADDR_W-1:0] row_addr,
  input logic [CNT_W-1:0]  raster,
  input logic              vsync,
  input logic              disp_en,
  input logic              curs_en,
  input logic              cycle_end
);

  AST_RASTER_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(hend) |-> $stable(raster)); // R1

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(hend) |-> $stable(row_addr)); // R3

  AST_START_LOAD: assert property (@(posedge clk) disable iff (rst)
    cycle_end |-> (row_addr == $past(r_start)) && (raster == '0)); // R3

  AST_END_ON_HEND: assert property (@(posedge clk) disable iff (rst)
    cycle_end |-> $past(hend)); // R9

  AST_VS_ROW_TOP: assert property (@(posedge clk) disable iff (rst)
    $rose(vsync) |-> ($past(raster) == '0)); // R5

  AST_VS_AFTER_LINE: assert property (@(posedge clk) disable iff (rst)
    $rose(vsync) |-> $past(hend, 2)); // R5

  AST_DISP_BLANK: assert property (@(posedge clk) disable iff (rst)
    (r_skew[1:0] == 2'b11) |=> !disp_en); // R7

  AST_CURS_BLANK: assert property (@(posedge clk) disable iff (rst)
    (r_skew[3:2] == 2'b11) |=> !curs_en); // R8

endmodule

bind vt_crtc_vert vt_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .hend(hend), .r_skew(r_skew), .r_start(r_start),
  .row_addr(row_addr), .raster(raster), .vsync(vsync),
  .disp_en(disp_en), .curs_en(curs_en), .cycle_end(cycle_end)
);

// File: tb/tb_vt_crtc_vert.sv
module tb_vt_crtc_vert;

  typedef struct {
    int vt; int ms; int adj; int vd; int vsp; int vsl; int skew; int start; int hd;
  } cfg_t;

  logic        clk = 1'b0;
  logic        rst, hend;
  logic [7:0]  r_vtotal, r_vdisp, r_vspos, r_hdisp;
  logic [4:0]  r_maxras, r_adjust;
  logic [3:0]  r_vslen, r_skew;
  logic [13:0] r_start;
  logic        disp_en, curs_en, vsync, cycle_end;
  logic [13:0] row_addr;
  logic [4:0]  raster;

  int n_chk = 0, n_fail = 0;
  int vs_left = 0;
  int prev_vis = 0;
  bit done = 0;
  cfg_t cfgs[21];

  always #4 clk = ~clk;

  vt_crtc_vert dut (
    .clk(clk), .rst(rst), .hend(hend),
    .r_vtotal(r_vtotal), .r_maxras(r_maxras), .r_adjust(r_adjust),
    .r_vdisp(r_vdisp), .r_vspos(r_vspos), .r_vslen(r_vslen),
    .r_skew(r_skew), .r_start(r_start), .r_hdisp(r_hdisp),
    .disp_en(disp_en), .curs_en(curs_en), .vsync(vsync),
    .row_addr(row_addr), .raster(raster), .cycle_end(cycle_end)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic apply_geo(input cfg_t c);
    r_vtotal = 8'(c.vt);  r_maxras = 5'(c.ms);  r_adjust = 5'(c.adj);
    r_vdisp  = 8'(c.vd);  r_vspos  = 8'(c.vsp); r_vslen  = 4'(c.vsl);
    r_start  = 14'(c.start); r_hdisp = 8'(c.hd);
  endtask

  function automatic int gate(input int code, input int j, input int vp, input int vn);
    if (code == 3) return 0;
    return (j < 1 + code) ? vp : vn;
  endfunction

  // j counts negedges after the edge that began this scanline
  task automatic check_line(input int e_ras, input string ras_tag, input int e_addr,
                            input int e_vs, input string vs_tag, input int e_cend,
                            input string cend_tag, input int vp, input int vn,
                            input int code, input int skew_after);
    for (int j = 0; j < 6; j++) begin
      if (j == 0) begin
        chk(ras_tag, int'(raster), e_ras);
        chk("R3 row_addr", int'(row_addr), e_addr);
        chk(cend_tag, int'(cycle_end), e_cend);
      end
      if (j == 1) begin
        chk(vs_tag, int'(vsync), e_vs);
        chk("R9 cycle_end width", int'(cycle_end), 0);
      end
      chk("R7 disp_en", int'(disp_en), gate(code & 3, j, vp, vn));
      chk("R8 curs_en", int'(curs_en), gate((code >> 2) & 3, j, vp, vn));
      @(negedge clk);
    end
    @(negedge clk);
    r_skew = 4'(skew_after);
    hend = 1'b1;
    @(negedge clk);
    hend = 1'b0;
  endtask

  task automatic run_cycle(input cfg_t c, input cfg_t nx, input bit first);
    int base, len, ras, rowm, addr, vis, w;
    string rt, vt_tag;
    base = (c.vt + 1) * (c.ms + 1);
    len  = base + c.adj;
    w    = (c.vsl == 0) ? 16 : c.vsl;
    for (int s = 0; s < len; s++) begin
      if (s < base) begin ras = s % (c.ms + 1); rowm = s / (c.ms + 1); rt = "R1 raster"; end
      else begin ras = s - base; rowm = c.vt + 1; rt = "R2 tail raster"; end
      addr = (c.start + rowm * c.hd) & 16'h3FFF;
      vis  = (rowm < c.vd) ? 1 : 0;
      if (!(first && s == 0)) begin
        if (rowm == c.vsp && ras == 0 && rowm <= c.vt) vs_left = w;
        else if (vs_left > 0) vs_left--;
      end
      vt_tag = (vs_left > 0) ? "R6 vsync pulse" : "R5 vsync";
      check_line(ras, rt, addr, (vs_left > 0) ? 1 : 0, vt_tag,
                 (s == 0 && !first) ? 1 : 0,
                 (s == 0) ? "R4 cycle start" : "R9 cycle_end",
                 prev_vis, vis, c.skew, (s == len - 1) ? nx.skew : c.skew);
      prev_vis = vis;
      if (s == 0) apply_geo(nx); // mid-cycle write, must wait for next cycle
    end
  endtask

  initial begin
    cfgs[0] = '{vt:3,  ms:2, adj:2, vd:2,  vsp:1,   vsl:2, skew:'h0, start:'h100,  hd:10};
    cfgs[1] = '{vt:2,  ms:3, adj:0, vd:5,  vsp:255, vsl:3, skew:'h5, start:'h3FF0, hd:20};
    cfgs[2] = '{vt:1,  ms:1, adj:3, vd:4,  vsp:0,   vsl:1, skew:'h6, start:'h0200, hd:7};
    cfgs[3] = '{vt:38, ms:7, adj:0, vd:25, vsp:31,  vsl:0, skew:'hF, start:'h0A00, hd:80};
    for (int ln = 0; ln < 8; ln++) begin
      cfgs[4 + 2*ln] = '{vt:13, ms:7, adj:8-ln, vd:1,  vsp:9,   vsl:2, skew:'hF, start:'h0760, hd:80};
      cfgs[5 + 2*ln] = '{vt:23, ms:7, adj:ln,   vd:25, vsp:255, vsl:2, skew:'hC, start:'h0800 + ln, hd:80};
    end
    cfgs[20] = cfgs[19];

    hend = 1'b0;
    rst  = 1'b1;
    apply_geo(cfgs[0]);
    r_skew = 4'(cfgs[0].skew);
    repeat (4) @(negedge clk);
    chk("R10 reset raster",    int'(raster), 0);
    chk("R10 reset row_addr",  int'(row_addr), 'h100);
    chk("R10 reset vsync",     int'(vsync), 0);
    chk("R10 reset disp_en",   int'(disp_en), 0);
    chk("R10 reset curs_en",   int'(curs_en), 0);
    chk("R10 reset cycle_end", int'(cycle_end), 0);
    rst = 1'b0;
    repeat (8) @(negedge clk);
    prev_vis = 1;

    for (int i = 0; i < 20; i++) run_cycle(cfgs[i], cfgs[i+1], i == 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule